// File: doc/BRIEF.md
# Slot Hot-Plug Event Register Block

This block gives platform firmware a register view of device insertion and removal across up to 32 slots. It holds a 16-bit general-purpose event status word and a matching enable word, both reached one byte at a time, plus two 32-bit slot bitmaps (one for slots that came up, one for slots that went down) and a 32-bit eject port. A hardware hot-plug event input, carrying a slot number and an insert/remove flag, rewrites the bitmaps, raises the hot-plug bit in the event status word and, when firmware has enabled that bit, sends a one-cycle pulse on the system control interrupt output.

Firmware reacts by reading the bitmaps, clearing the status bit with a write-one-to-clear byte access, and, for a removal, writing a mask to the eject port. The eject port turns the lowest set bit of that mask into a slot index and presents it for one cycle to the logic that performs the removal. Enumeration and slot power control sit outside this block.

Top module: `hp_event_regs`

## Requirements
- R1: After reset, all four event bytes read 0x00, both slot bitmaps read zero, and the interrupt and eject outputs are low.
- R2: A byte write to the event status word (byte offset 0 = bits 7:0, offset 1 = bits 15:8) clears exactly the bits written as one in the addressed byte; the other byte and the bits written as zero keep their values, and a write never sets a status bit.
- R3: A byte write to the event enable word (offset 2 = bits 7:0, offset 3 = bits 15:8) replaces the addressed byte only.
- R4: The event read port returns status low, status high, enable low and enable high for byte offsets 0, 1, 2 and 3.
- R5: The slot bitmaps are 32-bit read/write registers, the up map selected by map select 0 (offset 0) and the down map by map select 1 (offset 4).
- R6: A hot-plug event clears both bitmaps and then sets bit `slot` of the up map for an insert (insert flag 1) or of the down map for a removal (insert flag 0), so exactly one bitmap bit is set afterwards.
- R7: A hot-plug event sets bit 1 of the event status word.
- R8: The interrupt output is high for the one cycle after a hot-plug event when enable bit 1 is set at the event, and stays low otherwise.
- R9: A write of a nonzero value to the eject port raises eject valid for the following cycle with the index of the value's lowest set bit; a write of zero produces no eject.
- R10: The eject port reads as zero.
- R11: When a hot-plug event and a register write arrive in the same cycle, the event takes effect and the write to the event registers or the bitmaps is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gpe_we | input | 1 | Event register byte write strobe |
| gpe_addr | input | 2 | Event register byte offset |
| gpe_wdata | input | 8 | Event register write byte |
| gpe_rdata | output | 8 | Event register read byte at gpe_addr |
| map_we | input | 1 | Slot bitmap write strobe |
| map_sel | input | 1 | 0 selects up map, 1 selects down map |
| map_wdata | input | 32 | Slot bitmap write data |
| map_rdata | output | 32 | Selected slot bitmap |
| ej_we | input | 1 | Eject port write strobe |
| ej_wdata | input | 32 | Eject mask |
| ej_rdata | output | 32 | Eject port read data (zero) |
| hp_valid | input | 1 | Hot-plug event strobe |
| hp_slot | input | 5 | Slot of the event |
| hp_insert | input | 1 | 1 insert, 0 removal |
| sci | output | 1 | Event interrupt pulse |
| eject_valid | output | 1 | Eject request valid, one cycle |
| eject_slot | output | 5 | Slot index to remove |

## Verification
Hot-plug events are sent for an insert at a middle slot, a removal at the top slot and an insert at slot 0, over bitmaps preloaded with dense patterns, which shows whether the event clears both maps and picks the map by the insert flag. Events with the hot-plug enable bit set and cleared, and two back to back, separate gated from ungated interrupt pulses and count one pulse per event. Eject masks with a single bit, only the top bit, all bits and no bits show lowest-bit selection and the zero case, and events paired with writes in the same cycle show which side wins.

// File: rtl/hp_regs_pkg.sv
// Shared encodings for the hot-plug event register block.
// Assumes the event words are two bytes wide, so byte offsets fit two bits.
package hp_regs_pkg;

    // Byte offsets of the event register window.
    typedef enum logic [1:0] {
        EV_STS_LO = 2'd0,
        EV_STS_HI = 2'd1,
        EV_EN_LO  = 2'd2,
        EV_EN_HI  = 2'd3
    } ev_off_e;

    // Bitmap selection for the slot map window.
    typedef enum logic {
        MAP_UP   = 1'b0,
        MAP_DOWN = 1'b1
    } map_sel_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/ev_word_bank.sv
// Event status and enable words with byte-lane access.
// Status bits are only set by the hot-plug event and cleared by writing ones;
// enable bytes are plain replace-on-write. A pending event drops any write in
// the same cycle. Assumes status occupies offsets 0..BYTES-1 and enable
// occupies BYTES..2*BYTES-1, and that 2*BYTES is a power of two.
module ev_word_bank #(
    parameter int BYTES  = 2,
    parameter int HP_BIT = 1,
    localparam int WORD_W = 8 * BYTES,
    localparam int AW     = $clog2(2 * BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        wdata,
    input  logic              set_hp,
    output logic [WORD_W-1:0] sts,
    output logic [WORD_W-1:0] en,
    output logic [7:0]        rdata
);

    localparam logic [WORD_W-1:0] HP_MASK = WORD_W'(1) << HP_BIT;

    logic [2*WORD_W-1:0] window;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        localparam logic [AW-1:0] STS_OFF = AW'(b);
        localparam logic [AW-1:0] EN_OFF  = AW'(BYTES + b);

        // Status lane: event sets the hot-plug bit, a write clears ones.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts[8*b +: 8] <= '0;
            end else if (set_hp) begin
                sts[8*b +: 8] <= sts[8*b +: 8] | HP_MASK[8*b +: 8];
            end else if (we && addr == STS_OFF) begin
                sts[8*b +: 8] <= sts[8*b +: 8] & ~wdata;
            end
        end

        // Enable lane: a write replaces the addressed byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en[8*b +: 8] <= '0;
            end else if (!set_hp && we && addr == EN_OFF) begin
                en[8*b +: 8] <= wdata;
            end
        end
    end

    // Read mux over the byte window, enable above status.
    always_comb begin
        window = {en, sts};
        rdata  = window[8*addr +: 8];
    end

endmodule

// File: rtl/slot_bitmaps.sv
// Up and down slot bitmaps. A hot-plug event clears both and marks its slot
// in the map chosen by the insert flag; otherwise the bus may write either
// map. Assumes SLOTS <= DW; unused high read bits return zero.
module slot_bitmaps #(
    parameter int SLOTS = 32,
    parameter int DW    = 32,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [DW-1:0]    wdata,
    input  logic             ev_valid,
    input  logic [SW-1:0]    ev_slot,
    input  logic             ev_insert,
    output logic [SLOTS-1:0] up_map,
    output logic [SLOTS-1:0] down_map,
    output logic [DW-1:0]    rdata
);

    import hp_regs_pkg::*;

    logic [SLOTS-1:0] slot_bit;

    // One-hot mask for the event slot.
    always_comb begin
        slot_bit = SLOTS'(1) << ev_slot;
    end

    // Bitmap update: event first, bus write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_map   <= '0;
            down_map <= '0;
        end else if (ev_valid) begin
            up_map   <= ev_insert ? slot_bit : '0;
            down_map <= ev_insert ? '0 : slot_bit;
        end else if (we) begin
            if (sel == MAP_DOWN) down_map <= wdata[SLOTS-1:0];
            else                 up_map   <= wdata[SLOTS-1:0];
        end
    end

    // Read the selected map, zero-extended to the bus width.
    always_comb begin
        rdata = (sel == MAP_DOWN) ? DW'(down_map) : DW'(up_map);
    end

endmodule

// File: rtl/eject_picker.sv
// Eject port: converts a written mask into the index of its lowest set bit
// and presents it for one cycle. A zero mask yields no request.
module eject_picker #(
    parameter int DW = 32,
    localparam int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic          valid,
    output logic [IW-1:0] slot
);

    logic [IW-1:0] low_idx;

    // Priority search from the top so the lowest set bit wins.
    always_comb begin
        low_idx = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (wdata[i]) low_idx = IW'(i);
        end
    end

    // Register the request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            slot  <= '0;
        end else begin
            valid <= we && (wdata != '0);
            if (we && wdata != '0) slot <= low_idx;
        end
    end

endmodule

// File: rtl/hp_event_regs.sv
// Hot-plug event register block: event status/enable bytes, slot bitmaps,
// eject port and the event interrupt pulse. The hot-plug input has priority
// over same-cycle writes to the event words and bitmaps; the eject port is
// independent. Assumes a single-cycle hp_valid strobe per event.
module hp_event_regs #(
    parameter int NUM_SLOTS = 32,
    parameter int DATA_W    = 32,
    parameter int EV_BYTES  = 2,
    parameter int HP_BIT    = 1,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int EJ_W     = $clog2(DATA_W),
    localparam int EV_AW    = $clog2(2 * EV_BYTES),
    localparam int EV_W     = 8 * EV_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gpe_we,
    input  logic [EV_AW-1:0]  gpe_addr,
    input  logic [7:0]        gpe_wdata,
    output logic [7:0]        gpe_rdata,
    input  logic              map_we,
    input  logic              map_sel,
    input  logic [DATA_W-1:0] map_wdata,
    output logic [DATA_W-1:0] map_rdata,
    input  logic              ej_we,
    input  logic [DATA_W-1:0] ej_wdata,
    output logic [DATA_W-1:0] ej_rdata,
    input  logic              hp_valid,
    input  logic [SLOT_W-1:0] hp_slot,
    input  logic              hp_insert,
    output logic              sci,
    output logic              eject_valid,
    output logic [EJ_W-1:0]   eject_slot
);

    logic [EV_W-1:0]      ev_sts;
    logic [EV_W-1:0]      ev_en;
    logic [NUM_SLOTS-1:0] up_map;
    logic [NUM_SLOTS-1:0] down_map;

    ev_word_bank #(
        .BYTES  (EV_BYTES),
        .HP_BIT (HP_BIT)
    ) u_ev (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (gpe_we),
        .addr   (gpe_addr),
        .wdata  (gpe_wdata),
        .set_hp (hp_valid),
        .sts    (ev_sts),
        .en     (ev_en),
        .rdata  (gpe_rdata)
    );

    slot_bitmaps #(
        .SLOTS (NUM_SLOTS),
        .DW    (DATA_W)
    ) u_maps (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (map_we),
        .sel       (map_sel),
        .wdata     (map_wdata),
        .ev_valid  (hp_valid),
        .ev_slot   (hp_slot),
        .ev_insert (hp_insert),
        .up_map    (up_map),
        .down_map  (down_map),
        .rdata     (map_rdata)
    );

    eject_picker #(
        .DW (DATA_W)
    ) u_ej (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ej_we),
        .wdata (ej_wdata),
        .valid (eject_valid),
        .slot  (eject_slot)
    );

    // Eject port has no readable state.
    assign ej_rdata = '0;

    // Interrupt pulse: one cycle after an event whose enable bit is on.
    always_ff @(posedge clk) begin
        if (!rst_n) sci <= 1'b0;
        else        sci <= hp_valid && ev_en[HP_BIT];
    end

endmodule

// File: rtl/hp_event_regs_chk.sv
// Assertion checker for hp_event_regs, attached by bind. Assumes at least
// two event bytes so that the high status byte exists.
module hp_event_regs_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int DATA_W    = 32,
    parameter int EV_W      = 16,
    parameter int EV_AW     = 2,
    parameter int HP_BIT    = 1,
    parameter int EJ_W      = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 gpe_we,
    input logic [EV_AW-1:0]     gpe_addr,
    input logic                 hp_valid,
    input logic                 ej_we,
    input logic [DATA_W-1:0]    ej_wdata,
    input logic                 sci,
    input logic                 eject_valid,
    input logic [EJ_W-1:0]      eject_slot,
    input logic [EV_W-1:0]      ev_sts,
    input logic [EV_W-1:0]      ev_en,
    input logic [NUM_SLOTS-1:0] up_map,
    input logic [NUM_SLOTS-1:0] down_map
);

    assert_sts_no_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_we && !hp_valid) |=> ((ev_sts & ~$past(ev_sts)) == '0));

    assert_sts_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_we && gpe_addr == '0 && !hp_valid) |=> $stable(ev_sts[EV_W-1:8]));

    assert_en_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_we && gpe_addr == EV_AW'(2)) |=> $stable(ev_en[EV_W-1:8]));

    assert_event_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |=> ($countones({up_map, down_map}) == 1));

    assert_event_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |=> ev_sts[HP_BIT]);

    assert_sci_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> ($past(hp_valid) && $past(ev_en[HP_BIT])));

    assert_sci_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && !ev_en[HP_BIT]) |=> !sci);

    assert_eject_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eject_valid |-> ($past(ej_we) && $past(ej_wdata) != '0));

    assert_eject_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eject_valid |-> ((($past(ej_wdata) >> eject_slot) & DATA_W'(1)) == DATA_W'(1)));

    assert_en_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |=> $stable(ev_en));

endmodule

bind hp_event_regs hp_event_regs_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .EV_W      (EV_W),
    .EV_AW     (EV_AW),
    .HP_BIT    (HP_BIT),
    .EJ_W      (EJ_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gpe_we      (gpe_we),
    .gpe_addr    (gpe_addr),
    .hp_valid    (hp_valid),
    .ej_we       (ej_we),
    .ej_wdata    (ej_wdata),
    .sci         (sci),
    .eject_valid (eject_valid),
    .eject_slot  (eject_slot),
    .ev_sts      (ev_sts),
    .ev_en       (ev_en),
    .up_map      (up_map),
    .down_map    (down_map)
);

// File: tb/sim_hp_event_regs.sv
module sim_hp_event_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gpe_we = 1'b0;
    logic [1:0]  gpe_addr = '0;
    logic [7:0]  gpe_wdata = '0;
    logic [7:0]  gpe_rdata;
    logic        map_we = 1'b0;
    logic        map_sel = 1'b0;
    logic [31:0] map_wdata = '0;
    logic [31:0] map_rdata;
    logic        ej_we = 1'b0;
    logic [31:0] ej_wdata = '0;
    logic [31:0] ej_rdata;
    logic        hp_valid = 1'b0;
    logic [4:0]  hp_slot = '0;
    logic        hp_insert = 1'b0;
    logic        sci;
    logic        eject_valid;
    logic [4:0]  eject_slot;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int sci_q[$];   // one entry per expected interrupt pulse
    int ej_q[$];    // expected eject slot per request

    always #5 clk = ~clk;

    hp_event_regs u0 (
        .clk(clk), .rst_n(rst_n),
        .gpe_we(gpe_we), .gpe_addr(gpe_addr), .gpe_wdata(gpe_wdata), .gpe_rdata(gpe_rdata),
        .map_we(map_we), .map_sel(map_sel), .map_wdata(map_wdata), .map_rdata(map_rdata),
        .ej_we(ej_we), .ej_wdata(ej_wdata), .ej_rdata(ej_rdata),
        .hp_valid(hp_valid), .hp_slot(hp_slot), .hp_insert(hp_insert),
        .sci(sci), .eject_valid(eject_valid), .eject_slot(eject_slot)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Monitor: pops expected pulses as the outputs produce them.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sci) begin
                n_tests++;
                if (sci_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R8 actual=sci_pulse expected=no_pulse");
                end else begin
                    void'(sci_q.pop_front());
                end
            end
            if (eject_valid) begin
                if (ej_q.size() == 0) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL R9 actual=eject slot %0d expected=no_eject", eject_slot);
                end else begin
                    chk("R9", 32'(eject_slot), 32'(ej_q.pop_front()));
                end
            end
        end
    end

    task automatic gpe_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        gpe_addr = a; gpe_wdata = d; gpe_we = 1'b1;
        @(negedge clk);
        gpe_we = 1'b0;
    endtask

    task automatic gpe_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        gpe_addr = a;
        #1;
        chk(req, 32'(gpe_rdata), 32'(exp));
    endtask

    task automatic map_wr(input logic s, input logic [31:0] d);
        @(negedge clk);
        map_sel = s; map_wdata = d; map_we = 1'b1;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic map_chk(input string req, input logic s, input logic [31:0] exp);
        map_sel = s;
        #1;
        chk(req, map_rdata, exp);
    endtask

    // Hot-plug event, optionally with a same-cycle map or event-byte write.
    task automatic hp_evt(input logic [4:0] s, input logic ins, input bit exp_sci,
                          input bit with_map, input logic [31:0] mdata,
                          input bit with_gpe, input logic [1:0] ga, input logic [7:0] gd);
        @(negedge clk);
        hp_slot = s; hp_insert = ins; hp_valid = 1'b1;
        if (with_map) begin map_sel = 1'b0; map_wdata = mdata; map_we = 1'b1; end
        if (with_gpe) begin gpe_addr = ga; gpe_wdata = gd; gpe_we = 1'b1; end
        if (exp_sci) sci_q.push_back(1);
        @(negedge clk);
        hp_valid = 1'b0; map_we = 1'b0; gpe_we = 1'b0;
    endtask

    task automatic ej_wr(input logic [31:0] v);
        @(negedge clk);
        ej_wdata = v; ej_we = 1'b1;
        if (v != 0) begin
            for (int i = 31; i >= 0; i--) begin
                if (v[i] && ((v & ((32'd1 << i) - 32'd1)) == 0)) ej_q.push_back(i);
            end
        end
        @(negedge clk);
        ej_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        gpe_chk("R1", 2'd0, 8'h00);
        gpe_chk("R1", 2'd1, 8'h00);
        gpe_chk("R1", 2'd2, 8'h00);
        gpe_chk("R1", 2'd3, 8'h00);
        map_chk("R1", 1'b0, 32'h0);
        map_chk("R1", 1'b1, 32'h0);
        chk("R1", {30'd0, sci, eject_valid}, 32'd0);

        // R3 / R4: enable bytes replace only their own lane
        gpe_wr(2'd2, 8'h02);
        gpe_chk("R3", 2'd2, 8'h02);
        gpe_chk("R3", 2'd3, 8'h00);
        gpe_wr(2'd3, 8'hA5);
        gpe_chk("R4", 2'd3, 8'hA5);
        gpe_chk("R3", 2'd2, 8'h02);

        // R6 / R7 / R8: insert at slot 5 with enable on
        hp_evt(5'd5, 1'b1, 1, 0, 0, 0, 0, 0);
        map_chk("R6", 1'b0, 32'h0000_0020);
        map_chk("R6", 1'b1, 32'h0);
        gpe_chk("R7", 2'd0, 8'h02);
        gpe_chk("R4", 2'd1, 8'h00);

        // R5: bitmap read/write
        map_wr(1'b0, 32'hDEAD_BEEF);
        map_wr(1'b1, 32'h1234_5678);
        map_chk("R5", 1'b0, 32'hDEAD_BEEF);
        map_chk("R5", 1'b1, 32'h1234_5678);

        // R6: removal at slot 31 clears the dense maps
        hp_evt(5'd31, 1'b0, 1, 0, 0, 0, 0, 0);
        map_chk("R6", 1'b0, 32'h0);
        map_chk("R6", 1'b1, 32'h8000_0000);

        // R2: write-one-to-clear per lane
        gpe_wr(2'd0, 8'h00);
        gpe_chk("R2", 2'd0, 8'h02);
        gpe_wr(2'd1, 8'hFF);
        gpe_chk("R2", 2'd0, 8'h02);
        gpe_wr(2'd0, 8'hFD);
        gpe_chk("R2", 2'd0, 8'h02);
        gpe_wr(2'd0, 8'h02);
        gpe_chk("R2", 2'd0, 8'h00);

        // R8: enable off, event gives no pulse but sets status
        gpe_wr(2'd2, 8'h00);
        hp_evt(5'd0, 1'b1, 0, 0, 0, 0, 0, 0);
        gpe_chk("R7", 2'd0, 8'h02);
        map_chk("R6", 1'b0, 32'h0000_0001);

        // R11: event beats same-cycle map write and enable write
        hp_evt(5'd7, 1'b1, 0, 1, 32'h0000_FFFF, 1, 2'd2, 8'h02);
        map_chk("R11", 1'b0, 32'h0000_0080);
        gpe_chk("R11", 2'd2, 8'h00);
        // R11: event beats same-cycle status clear
        hp_evt(5'd9, 1'b0, 0, 0, 0, 1, 2'd0, 8'hFF);
        gpe_chk("R11", 2'd0, 8'h02);
        map_chk("R11", 1'b1, 32'h0000_0200);

        // R8: back-to-back events with enable on give one pulse each
        gpe_wr(2'd2, 8'h02);
        @(negedge clk);
        hp_slot = 5'd3; hp_insert = 1'b1; hp_valid = 1'b1;
        sci_q.push_back(1);
        @(negedge clk);
        hp_slot = 5'd4;
        sci_q.push_back(1);
        @(negedge clk);
        hp_valid = 1'b0;
        map_chk("R6", 1'b0, 32'h0000_0010);

        // R9 / R10: eject lowest set bit, zero mask ignored
        ej_wr(32'h0000_0010);
        ej_wr(32'h8000_0000);
        ej_wr(32'hFFFF_FFFF);
        ej_wr(32'h0000_0000);
        ej_wr(32'h0060_0000);
        chk("R10", ej_rdata, 32'h0);

        repeat (4) @(negedge clk);
        chk("R8", 32'(sci_q.size()), 32'd0);
        chk("R9", 32'(ej_q.size()), 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule